// File: doc/BRIEF.md
# Serial display frame loader

This block sits on the host side of a serial-input, latched display driver. It takes one display frame per valid/ready handshake and moves it into the driver over four wires: a serial data line, a shift clock, a latch-enable pulse and a blanking strobe. The driver samples the data line on each rising shift-clock edge. Once every bit has gone in, a latch pulse copies the driver's shift register onto its outputs.

All serial timing is counted in system-clock cycles. Parameters set the shortest shift-clock low phase, the shortest high phase, the data setup and hold intervals, and the width of the latch pulse. From these the block derives a fixed length for each clock phase. It also guarantees that the data line only changes while the shift clock is low. A frame always runs the same way: it is shifted out MSB first, latched once, and then the block returns to idle. A separate blank input forces the strobe high at any time. While the strobe is high the driver holds every output low.

Top module: `serial_frame_loader`

## Requirements
- R1: After synchronous reset the block is idle: `frm_ready` is 1 and `disp_sclk`, `disp_latch` and `disp_sdat` are 0.
- R2: A frame is taken on a rising clock edge where `frm_valid` and `frm_ready` are both 1. From the next cycle `frm_ready` stays 0 until the cycle after `disp_latch` falls, and it is 0 in every cycle where `disp_sclk` or `disp_latch` is 1.
- R3: Bits go out most significant first. The k-th rising edge of `disp_sclk` (k = 1..FRAME_W) carries bit FRAME_W-k of the frame, so a driver that shifts toward higher stage numbers ends with bit 0 in its first stage and bit FRAME_W-1 in its last.
- R4: Each frame makes exactly FRAME_W rising edges of `disp_sclk`, and all of them come before the latch pulse.
- R5: Each low phase between two shift-clock edges lasts max(CLK_LO_CYC, SETUP_CYC, 1) cycles. Each high phase lasts max(CLK_HI_CYC, HOLD_CYC, 1) cycles.
- R6: `disp_sdat` is unchanged for at least SETUP_CYC cycles before every rising shift-clock edge. After that edge it stays unchanged for at least HOLD_CYC cycles.
- R7: `disp_sdat` changes only in cycles where `disp_sclk` is 0.
- R8: `disp_latch` rises in the same cycle that the last high phase ends, with `disp_sclk` low. It stays high for max(LATCH_CYC, 1) cycles and is low for the whole shift, so the driver keeps its previous outputs until the latch pulse.
- R9: `disp_blank` follows `blank_req` in the same cycle, whatever the sequence state. Shifting and latching go on while the outputs are blanked.
- R10: A `frm_valid` or a change of `frm_data` while `frm_ready` is 0 has no effect on the frame in progress. A frame offered during that time is taken in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | Frame offered |
| frm_data | input | FRAME_W | Frame bits; bit FRAME_W-1 is sent first |
| frm_ready | output | 1 | Block idle, able to take a frame |
| blank_req | input | 1 | Blank all display outputs |
| disp_sdat | output | 1 | Serial data to the driver |
| disp_sclk | output | 1 | Shift clock to the driver; data is sampled on its rising edge |
| disp_latch | output | 1 | Latch-enable pulse to the driver |
| disp_blank | output | 1 | Strobe: 1 blanks the outputs, 0 enables them |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the blank input and the latch pulse. The bench raises `blank_req` in the middle of a shift and holds it through the latch pulse. It checks that the strobe is high in that same cycle, that the modelled driver outputs read zero, and that releasing the blank shows the newly latched frame. The second pair is the end of one frame and the arrival of the next. The bench holds `frm_valid` high and changes `frm_data` for the whole busy period. It then checks that the first frame is shifted and latched untouched, and that the waiting frame is taken in the very first idle cycle. Throughout all of this, a driver model in the bench checks every shift edge for bit order, phase length, setup and hold.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SHIFT_LO = 3'd1,
    ST_SHIFT_HI = 3'd2,
    ST_LATCH    = 3'd3,
    ST_DONE     = 3'd4
  } sfl_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sfl_phase_timer.sv
// Down-counter that times one phase; expired is high in the last cycle of a phase.
module sfl_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sfl_shifter.sv
// Frame holding register, emptied MSB first, with the count of bits already clocked out.
module sfl_shifter #(
  parameter int FRAME_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic               step,
  output logic               ser_bit,
  output logic               last_bit
);

  localparam int BCNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [BCNT_W-1:0] LAST_IDX = BCNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sr_q;
  logic [BCNT_W-1:0]  bcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= frame;
    end else if (step) begin
      sr_q <= {sr_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt_q <= '0;
    end else if (load) begin
      bcnt_q <= '0;
    end else if (step) begin
      bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assign ser_bit  = sr_q[FRAME_W-1];
  assign last_bit = (bcnt_q == LAST_IDX);

endmodule

// File: rtl/sfl_sequencer.sv
// Ordering control: shift low/high phases, then one latch pulse, then idle.
module sfl_sequencer
  import sfl_pkg::*;
#(
  parameter int unsigned LOW_LEN   = 2,
  parameter int unsigned HIGH_LEN  = 2,
  parameter int unsigned LATCH_LEN = 2,
  parameter int          CNT_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             expired,
  input  logic             last_bit,
  output logic             in_ready,
  output logic             ld_frame,
  output logic             step,
  output logic             t_load,
  output logic [CNT_W-1:0] t_val,
  output logic             sclk_o,
  output logic             lat_o
);

  localparam logic [CNT_W-1:0] LOW_RLD   = CNT_W'(LOW_LEN - 1);
  localparam logic [CNT_W-1:0] HIGH_RLD  = CNT_W'(HIGH_LEN - 1);
  localparam logic [CNT_W-1:0] LATCH_RLD = CNT_W'(LATCH_LEN - 1);

  sfl_state_e state_q, state_d;
  logic       sclk_q, lat_q;

  always_comb begin
    state_d  = state_q;
    ld_frame = 1'b0;
    step     = 1'b0;
    t_load   = 1'b0;
    t_val    = LOW_RLD;
    unique case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          ld_frame = 1'b1;
          t_load   = 1'b1;
          t_val    = LOW_RLD;
          state_d  = ST_SHIFT_LO;
        end
      end
      ST_SHIFT_LO: begin
        if (expired) begin
          t_load  = 1'b1;
          t_val   = HIGH_RLD;
          state_d = ST_SHIFT_HI;
        end
      end
      ST_SHIFT_HI: begin
        if (expired) begin
          t_load = 1'b1;
          if (last_bit) begin
            t_val   = LATCH_RLD;
            state_d = ST_LATCH;
          end else begin
            step    = 1'b1;
            t_val   = LOW_RLD;
            state_d = ST_SHIFT_LO;
          end
        end
      end
      ST_LATCH: begin
        if (expired) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b0;
      lat_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sclk_q  <= (state_d == ST_SHIFT_HI);
      lat_q   <= (state_d == ST_LATCH);
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign sclk_o   = sclk_q;
  assign lat_o    = lat_q;

endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader
  import sfl_pkg::*;
#(
  parameter int FRAME_W    = 32,
  parameter int SETUP_CYC  = 8,
  parameter int HOLD_CYC   = 8,
  parameter int CLK_HI_CYC = 9,
  parameter int CLK_LO_CYC = 9,
  parameter int LATCH_CYC  = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frm_valid,
  input  logic [FRAME_W-1:0] frm_data,
  output logic               frm_ready,
  input  logic               blank_req,
  output logic               disp_sdat,
  output logic               disp_sclk,
  output logic               disp_latch,
  output logic               disp_blank
);

  // Setup is absorbed into the low phase, hold into the high phase; every interval is at least one cycle.
  localparam int unsigned LOW_LEN   = max2(max2(CLK_LO_CYC, SETUP_CYC), 1);
  localparam int unsigned HIGH_LEN  = max2(max2(CLK_HI_CYC, HOLD_CYC), 1);
  localparam int unsigned LATCH_LEN = max2(LATCH_CYC, 1);
  localparam int unsigned MAX_LEN   = max2(max2(LOW_LEN, HIGH_LEN), LATCH_LEN);
  localparam int          TMR_W     = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  logic             ld_frame, step, t_load, expired, last_bit;
  logic [TMR_W-1:0] t_val;

  sfl_phase_timer #(
    .CNT_W (TMR_W)
  ) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (expired)
  );

  sfl_shifter #(
    .FRAME_W (FRAME_W)
  ) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .load     (ld_frame),
    .frame    (frm_data),
    .step     (step),
    .ser_bit  (disp_sdat),
    .last_bit (last_bit)
  );

  sfl_sequencer #(
    .LOW_LEN   (LOW_LEN),
    .HIGH_LEN  (HIGH_LEN),
    .LATCH_LEN (LATCH_LEN),
    .CNT_W     (TMR_W)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .in_valid (frm_valid),
    .expired  (expired),
    .last_bit (last_bit),
    .in_ready (frm_ready),
    .ld_frame (ld_frame),
    .step     (step),
    .t_load   (t_load),
    .t_val    (t_val),
    .sclk_o   (disp_sclk),
    .lat_o    (disp_latch)
  );

  // Blanking bypasses the sequence so it takes effect in the same cycle.
  assign disp_blank = blank_req;

endmodule

// File: rtl/sfl_checker.sv
module sfl_checker #(
  parameter int W = 32
) (
  input logic clk,
  input logic rst,
  input logic frm_valid,
  input logic frm_ready,
  input logic sdat,
  input logic sclk,
  input logic lat_en
);

  localparam int RW = $clog2(W + 1);

  logic [RW-1:0] rises_q;
  logic          p_sclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rises_q  <= '0;
      p_sclk_q <= 1'b0;
    end else begin
      p_sclk_q <= sclk;
      if (frm_valid && frm_ready) begin
        rises_q <= '0;
      end else if (sclk && !p_sclk_q) begin
        rises_q <= rises_q + 1'b1;
      end
    end
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_ready) |=> !frm_ready);

  // R7
  sdat_moves_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdat) |-> !sclk);

  // R6
  sdat_steady_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdat));

  // R8
  latch_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_en) |-> $fell(sclk));

  // R8
  latch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lat_en |-> (!sclk && !frm_ready));

  // R4
  edge_count_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lat_en) |-> (rises_q == RW'(W)));

endmodule

bind serial_frame_loader sfl_checker #(.W(FRAME_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .frm_valid (frm_valid),
  .frm_ready (frm_ready),
  .sdat      (disp_sdat),
  .sclk      (disp_sclk),
  .lat_en    (disp_latch)
);

// File: tb/serial_frame_loader_tb_top.sv
module serial_frame_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 32;
  localparam int SETUP      = 3;
  localparam int HOLD       = 3;
  localparam int CHI        = 2;
  localparam int CLO        = 2;
  localparam int LAT        = 2;
  localparam int LOW_LEN    = (CLO > SETUP) ? CLO : SETUP;
  localparam int HIGH_LEN   = (CHI > HOLD) ? CHI : HOLD;

  logic         clk, rst, frm_valid, frm_ready, blank_req;
  logic [W-1:0] frm_data;
  logic         disp_sdat, disp_sclk, disp_latch, disp_blank;

  serial_frame_loader #(
    .FRAME_W (W), .SETUP_CYC (SETUP), .HOLD_CYC (HOLD),
    .CLK_HI_CYC (CHI), .CLK_LO_CYC (CLO), .LATCH_CYC (LAT)
  ) dut_i (
    .clk (clk), .rst (rst), .frm_valid (frm_valid), .frm_data (frm_data),
    .frm_ready (frm_ready), .blank_req (blank_req), .disp_sdat (disp_sdat),
    .disp_sclk (disp_sclk), .disp_latch (disp_latch), .disp_blank (disp_blank)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver model: shift on the rising shift clock, transparent latch, blanking strobe.
  logic [W-1:0] drv_sr = '0;
  logic [W-1:0] drv_lat = '0;
  wire  [W-1:0] drv_out = disp_blank ? '0 : drv_lat;

  always @(posedge disp_sclk) drv_sr <= {drv_sr[W-2:0], disp_sdat};
  always @(negedge clk) if (disp_latch) drv_lat = drv_sr;

  // Serial timing monitor
  bit           mon_on = 1'b0;
  logic         p_sclk = 1'b0, p_sdat = 1'b0, p_lat = 1'b0;
  int           age = 0, since_rise = 1000, lo_run = 0, hi_run = 0, lat_run = 0;
  int           edge_idx = 0, rdy_bad = 0;
  logic [W-1:0] exp_frame = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      automatic bit rise = disp_sclk && !p_sclk;
      automatic bit fall = !disp_sclk && p_sclk;
      automatic bit chg  = (disp_sdat !== p_sdat);
      age        = chg ? 1 : age + 1;
      since_rise = rise ? 0 : since_rise + 1;
      if (chg) begin
        chk(!disp_sclk, "R7 data moved with clock high", W'(disp_sclk), '0);
        if (edge_idx > 0) chk(since_rise >= HOLD, "R6 hold", W'(since_rise), W'(HOLD));
      end
      if (rise) begin
        if (edge_idx > 0) chk(lo_run == LOW_LEN, "R5 low phase", W'(lo_run), W'(LOW_LEN));
        chk(age - 1 >= SETUP, "R6 setup", W'(age - 1), W'(SETUP));
        chk(edge_idx < W, "R4 extra edge", W'(edge_idx), W'(W - 1));
        if (edge_idx < W)
          chk(disp_sdat == exp_frame[W-1-edge_idx], "R3 bit order", W'(disp_sdat), W'(exp_frame[W-1-edge_idx]));
        edge_idx++;
        hi_run = 1;
      end else if (disp_sclk) begin
        hi_run++;
      end
      if (fall) begin
        chk(hi_run == HIGH_LEN, "R5 high phase", W'(hi_run), W'(HIGH_LEN));
        lo_run = 1;
      end else if (!disp_sclk) begin
        lo_run++;
      end
      if (disp_latch && !p_lat) begin
        chk(edge_idx == W, "R4 edges before latch", W'(edge_idx), W'(W));
        chk(!disp_sclk, "R8 latch with clock low", W'(disp_sclk), '0);
        lat_run = 1;
      end else if (disp_latch) begin
        lat_run++;
      end
      if (!disp_latch && p_lat) begin
        chk(lat_run == LAT, "R8 latch width", W'(lat_run), W'(LAT));
        chk(!frm_ready, "R2 ready low after latch fall", W'(frm_ready), '0);
      end
      if ((disp_sclk || disp_latch) && frm_ready) rdy_bad++;
      p_sclk = disp_sclk;
      p_sdat = disp_sdat;
      p_lat  = disp_latch;
    end
  end

  // Called at a negedge; returns at the negedge after the accepting edge.
  task automatic start_frame(input logic [W-1:0] d, input bit keep_valid);
    frm_data  = d;
    frm_valid = 1'b1;
    exp_frame = d;
    edge_idx  = 0;
    rdy_bad   = 0;
    while (!frm_ready) @(negedge clk);
    @(negedge clk);
    if (!keep_valid) frm_valid = 1'b0;
    chk(!frm_ready, "R2 ready low after accept", W'(frm_ready), '0);
  endtask

  task automatic finish_frame(input string tag);
    while (!frm_ready) @(negedge clk);
    chk(edge_idx == W, {tag, " R4 edge count"}, W'(edge_idx), W'(W));
    chk(drv_sr == exp_frame, {tag, " R3 driver register"}, drv_sr, exp_frame);
    chk(drv_lat == exp_frame, {tag, " R3 latched frame"}, drv_lat, exp_frame);
    chk(rdy_bad == 0, {tag, " R2 ready while busy"}, W'(rdy_bad), '0);
  endtask

  task automatic run_frame(input logic [W-1:0] d);
    start_frame(d, 1'b0);
    finish_frame("sweep");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] prev;
    rst = 1'b1; frm_valid = 1'b0; frm_data = '0; blank_req = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(frm_ready == 1'b1, "R1 ready", W'(frm_ready), W'(1));
    chk(disp_sclk == 1'b0, "R1 sclk", W'(disp_sclk), '0);
    chk(disp_latch == 1'b0, "R1 latch", W'(disp_latch), '0);
    chk(disp_sdat == 1'b0, "R1 sdat", W'(disp_sdat), '0);
    chk(disp_blank == 1'b0, "R9 strobe low", W'(disp_blank), '0);
    mon_on = 1'b1;

    // R3: bit 0 ends in the first stage
    run_frame(W'(1));
    chk(drv_lat[0] == 1'b1 && drv_lat[W-1] == 1'b0, "R3 first stage holds bit 0", drv_lat, W'(1));

    run_frame('0);
    run_frame('1);
    run_frame(32'hA5A5_A5A5);
    run_frame(32'h5A5A_5A5A);
    run_frame(32'h1234_5678);
    for (int i = 0; i < W; i++) run_frame(W'(1) << i);
    for (int i = 0; i < 8; i++) run_frame(~(W'(1) << (i * 4)));

    // R8: previous latched value persists during the shift
    prev = drv_lat;
    start_frame(32'hC3C3_0F0F, 1'b0);
    repeat (40) @(negedge clk);
    chk(drv_lat == prev, "R8 old data kept while shifting", drv_lat, prev);
    finish_frame("persist");

    // R10: valid held and data changed while busy
    start_frame(32'h0BAD_F00D, 1'b1);
    frm_data = 32'h7E57_1DEA;
    repeat (30) @(negedge clk);
    frm_data = 32'hFFFF_0000;
    finish_frame("R10 busy");
    chk(drv_lat == 32'h0BAD_F00D, "R10 frame unchanged by busy inputs", drv_lat, 32'h0BAD_F00D);
    chk(frm_valid == 1'b1, "R10 offer still pending", W'(frm_valid), W'(1));
    start_frame(32'hFFFF_0000, 1'b0);
    finish_frame("R10 next");

    // R9: blank in mid-shift and through the latch pulse
    start_frame(32'h9696_6969, 1'b0);
    repeat (20) @(negedge clk);
    blank_req = 1'b1;
    #1;
    chk(disp_blank == 1'b1, "R9 strobe follows blank", W'(disp_blank), W'(1));
    chk(drv_out == '0, "R9 outputs blanked", drv_out, '0);
    while (!disp_latch) @(negedge clk);
    chk(disp_blank == 1'b1 && drv_out == '0, "R9 blank during latch", drv_out, '0);
    finish_frame("R9 blanked");
    blank_req = 1'b0;
    #1;
    chk(disp_blank == 1'b0, "R9 strobe released", W'(disp_blank), '0);
    chk(drv_out == 32'h9696_6969, "R9 new frame shown", drv_out, 32'h9696_6969);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule